// File: doc/BRIEF.md
# Masked configuration register file

This block holds the 256-byte configuration space of one bus function. Each access names a target with a 24-bit address made of a bus number, a device/function number and a byte offset. The block serves only the target fixed by its parameters. An access to any other target reads back as all ones and writes nothing.

Writes merge through a write mask held for each byte. Identity fields, subsystem fields and the other read-only header bytes keep their reset values, while the enable bits, base address registers and the device-specific area above the header accept new data. Read data is little-endian. Near the top of the space, a read that is too wide for its offset drops to a narrower width. When a write changes a base address register byte, or changes the IO or memory enable bit, the block raises a one-cycle remap request. Logic that owns the address decode uses this request to rebuild its mappings.

Top module: `cfg_space_regfile`

## Requirements
- R1: An access targets this block only when address bits 23:16 equal `BUS_NUM` and bits 15:8 equal `DEVFN` (slot in bits 15:11, function in bits 10:8). Bits 7:0 give the byte offset.
- R2: A read request (`req_i` high, `we_i` low) drives `rvalid_o` high in the next cycle, and only then. The byte at the offset appears in `rdata_o[7:0]` and each following byte in the next higher lane.
- R3: `size_i` 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 select 4 bytes. Read lanes beyond the served width return zero.
- R4: A read that misses returns 0xFF, 0xFFFF or 0xFFFFFFFF for 1, 2 or 4 bytes. A write that misses changes no byte and raises no remap.
- R5: A 4-byte read is served at offsets up to 0xFC. Above 0xFC it becomes a 2-byte read, which is served up to 0xFE. Above 0xFE the read returns 1 byte.
- R6: A written byte becomes (old AND NOT mask) OR (new AND mask). Lanes that would fall past offset 0xFF are dropped.
- R7: In the header, these bits are writable: command byte 0x04 bits 2:0 (bit 0 IO enable, bit 1 memory enable, bit 2 bus-master enable), offsets 0x0C and 0x3C fully, and each base address register at 0x10–0x27 through `BAR_WMASK`. All other header bits are read-only, including identity, subsystem, 0x05, 0x28 and 0x3D.
- R8: Offsets 0x40 to 0xFF are fully writable.
- R9: After reset, offsets 0x00–0x01 hold `VENDOR_ID`, 0x02–0x03 `DEVICE_ID`, 0x08 `REVISION`, 0x09–0x0B `CLASS_CODE`, 0x2C–0x2D `SUBSYS_VENDOR` and 0x2E–0x2F `SUBSYS_ID`, all little-endian. Every other byte is zero, and `rvalid_o` and `remap_o` are low.
- R10: `remap_o` goes high for one cycle, in the cycle after a write, when that write changed a byte in 0x10–0x27 or bit 0 or 1 of offset 0x04. A write that changes neither leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Bus, device/function and byte offset |
| size_i | input | 2 | Access width code |
| wdata_i | input | 32 | Write data, little-endian lanes |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| remap_o | output | 1 | Mapping change pulse |

## Verification
Read data, `rvalid_o` and `remap_o` all come from one register stage, so each result is due exactly one clock after the request cycle. The bench drives each request on a falling edge and samples the outputs on the next falling edge. For each access in the table it checks the read value, or the remap pulse and the quiet `rvalid_o` for a write. Directed tests sample one further cycle to confirm that both `remap_o` and `rvalid_o` last a single cycle. They also confirm that a reset applied in mid-run restores the stored bytes.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned CMD_OFF = 8'h04;
  localparam int unsigned BAR_LO  = 8'h10;
  localparam int unsigned BAR_HI  = 8'h27;
  localparam int unsigned HDR_END = 8'h40;

  function automatic logic [7:0] byte_wmask(input int unsigned off, input logic [31:0] bar_wm);
    if (off == CMD_OFF)                     return 8'h07;
    if (off == 8'h0C || off == 8'h3C)       return 8'hFF;
    if (off >= BAR_LO && off <= BAR_HI)     return bar_wm[8*(off%4) +: 8];
    if (off >= HDR_END)                     return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] reset_byte(input int unsigned off,
      input logic [15:0] vid, input logic [15:0] did, input logic [7:0] rev,
      input logic [23:0] cls, input logic [15:0] svid, input logic [15:0] sid);
    case (off)
      8'h00: return vid[7:0];
      8'h01: return vid[15:8];
      8'h02: return did[7:0];
      8'h03: return did[15:8];
      8'h08: return rev;
      8'h09: return cls[7:0];
      8'h0A: return cls[15:8];
      8'h0B: return cls[23:16];
      8'h2C: return svid[7:0];
      8'h2D: return svid[15:8];
      8'h2E: return sid[7:0];
      8'h2F: return sid[15:8];
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_route.sv
module cfg_route #(
  parameter logic [7:0] BUS_NUM = 8'h02,
  parameter logic [7:0] DEVFN   = 8'h18,
  parameter int unsigned NBYTES = 256,
  localparam int unsigned AW    = $clog2(NBYTES)
) (
  input  logic [23:0]   addr_i,
  input  logic [1:0]    size_i,
  output logic          hit_o,
  output logic [AW-1:0] off_o,
  output logic [2:0]    req_len_o,
  output logic [2:0]    rd_len_o
);
  assign hit_o = (addr_i[23:16] == BUS_NUM) && (addr_i[15:8] == DEVFN);
  assign off_o = addr_i[AW-1:0];

  always_comb begin
    case (size_i)
      2'd0:    req_len_o = 3'd1;
      2'd1:    req_len_o = 3'd2;
      default: req_len_o = 3'd4;
    endcase
    // narrow the read until it fits below the top of the space
    if (req_len_o == 3'd4 && int'(off_o) <= int'(NBYTES) - 4)      rd_len_o = 3'd4;
    else if (req_len_o >= 3'd2 && int'(off_o) <= int'(NBYTES) - 2) rd_len_o = 3'd2;
    else                                                           rd_len_o = 3'd1;
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_pkg::*;
#(
  parameter int unsigned NBYTES        = 256,
  parameter int unsigned LANES         = 4,
  parameter logic [31:0] BAR_WMASK     = 32'hFFFF_F000,
  parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID     = 16'h5A17,
  parameter logic [7:0]  REVISION      = 8'h03,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h7E11,
  parameter logic [15:0] SUBSYS_ID     = 16'h0042,
  localparam int unsigned AW           = $clog2(NBYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         off_i,
  input  logic [2:0]            len_i,
  input  logic [8*LANES-1:0]    wdata_i,
  output logic [NBYTES-1:0][7:0] mem_o,
  output logic                  change_o
);
  logic [NBYTES-1:0] chg;

  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    localparam logic [7:0] WM = byte_wmask(j, BAR_WMASK);
    localparam logic [7:0] RV = reset_byte(j, VENDOR_ID, DEVICE_ID, REVISION,
                                           CLASS_CODE, SUBSYS_VENDOR, SUBSYS_ID);
    logic       sel;
    logic [7:0] din, nxt, q;

    always_comb begin
      sel = 1'b0;
      din = 8'h00;
      for (int k = 0; k < int'(LANES); k++) begin
        if (wr_en_i && k < int'(len_i) && int'(off_i) + k == j) begin
          sel = 1'b1;
          din = wdata_i[8*k +: 8];
        end
      end
    end

    assign nxt = (q & ~WM) | (din & WM);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= RV;
      else if (sel) q <= nxt;
    end

    if (j >= BAR_LO && j <= BAR_HI) begin : g_bar
      assign chg[j] = sel && (nxt != q);
    end else if (j == CMD_OFF) begin : g_cmd
      assign chg[j] = sel && (nxt[1:0] != q[1:0]);
    end else begin : g_none
      assign chg[j] = 1'b0;
    end

    assign mem_o[j] = q;
  end

  assign change_o = |chg;
endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile #(
  parameter logic [7:0]  BUS_NUM       = 8'h02,
  parameter logic [7:0]  DEVFN         = 8'h18,
  parameter int unsigned NBYTES        = 256,
  parameter int unsigned LANES         = 4,
  parameter logic [31:0] BAR_WMASK     = 32'hFFFF_F000,
  parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID     = 16'h5A17,
  parameter logic [7:0]  REVISION      = 8'h03,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h7E11,
  parameter logic [15:0] SUBSYS_ID     = 16'h0042
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [23:0] addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic        rvalid_o,
  output logic [31:0] rdata_o,
  output logic        remap_o
);
  localparam int unsigned AW = $clog2(NBYTES);
  localparam int unsigned DW = 8 * LANES;

  logic                   hit;
  logic [AW-1:0]          off;
  logic [2:0]             req_len, rd_len;
  logic [NBYTES-1:0][7:0] mem;
  logic                   change;
  logic [DW-1:0]          rdata_c;
  logic                   rd_req, wr_en;

  assign rd_req = req_i && !we_i;
  assign wr_en  = req_i && we_i && hit;

  cfg_route #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN), .NBYTES(NBYTES)) u_route (
    .addr_i(addr_i), .size_i(size_i), .hit_o(hit), .off_o(off),
    .req_len_o(req_len), .rd_len_o(rd_len)
  );

  cfg_store #(
    .NBYTES(NBYTES), .LANES(LANES), .BAR_WMASK(BAR_WMASK),
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .CLASS_CODE(CLASS_CODE), .SUBSYS_VENDOR(SUBSYS_VENDOR), .SUBSYS_ID(SUBSYS_ID)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .off_i(off),
    .len_i(req_len), .wdata_i(wdata_i[DW-1:0]), .mem_o(mem), .change_o(change)
  );

  always_comb begin
    rdata_c = '0;
    for (int k = 0; k < int'(LANES); k++) begin
      if (hit) begin
        if (k < int'(rd_len)) rdata_c[8*k +: 8] = mem[off + AW'(k)];
      end else if (k < int'(req_len)) begin
        rdata_c[8*k +: 8] = 8'hFF;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      remap_o  <= 1'b0;
    end else begin
      rvalid_o <= rd_req;
      remap_o  <= change;
      if (rd_req) rdata_o <= 32'(rdata_c);
    end
  end
endmodule

// File: rtl/cfg_space_regfile_chk.sv
module cfg_space_regfile_chk #(
  parameter logic [7:0] BUS_NUM = 8'h02,
  parameter logic [7:0] DEVFN   = 8'h18
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [23:0] addr_i,
  input logic [1:0]  size_i,
  input logic        rvalid_o,
  input logic [31:0] rdata_o,
  input logic        remap_o
);
  logic own;
  assign own = (addr_i[23:8] == {BUS_NUM, DEVFN});

  p_rvalid_after_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_rvalid_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  p_absent_byte_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !own && size_i == 2'd0) |=> (rdata_o == 32'h0000_00FF));

  p_absent_word_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !own && size_i[1]) |=> (rdata_o == 32'hFFFF_FFFF));

  p_byte_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == 2'd0) |=> (rdata_o[31:8] == 24'h0));

  p_remap_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o |-> $past(req_i && we_i && own));
endmodule

bind cfg_space_regfile cfg_space_regfile_chk #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .size_i(size_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .remap_o(remap_o)
);

// File: tb/sim_cfg_space_regfile.sv
`timescale 1ns/1ps
module sim_cfg_space_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        rvalid, remap;
  logic [31:0] rdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cfg_space_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .remap_o(remap)
  );

  // {req[95:92], we[91], size[90:89], addr[88:65], wdata[64:33], expect[32:1], remap[0]}
  localparam int NV = 42;
  localparam logic [95:0] TBL [NV] = '{
    {4'd9, 1'b0,2'd2,24'h021800,32'h0,32'h5A17C0DE,1'b0},        // R9 identity
    {4'd9, 1'b0,2'd2,24'h021808,32'h0,32'h02000003,1'b0},        // R9 rev/class
    {4'd9, 1'b0,2'd1,24'h02182C,32'h0,32'h00007E11,1'b0},        // R9 subsys vendor
    {4'd9, 1'b0,2'd1,24'h02182E,32'h0,32'h00000042,1'b0},        // R9 subsys id
    {4'd7, 1'b1,2'd2,24'h021800,32'hFFFFFFFF,32'h0,1'b0},        // R7 identity write
    {4'd7, 1'b0,2'd2,24'h021800,32'h0,32'h5A17C0DE,1'b0},
    {4'd7, 1'b1,2'd2,24'h02182C,32'h12345678,32'h0,1'b0},        // R7 subsys write
    {4'd7, 1'b0,2'd2,24'h02182C,32'h0,32'h00427E11,1'b0},
    {4'd7, 1'b1,2'd0,24'h02180C,32'h000000AB,32'h0,1'b0},        // R7 cache line
    {4'd7, 1'b0,2'd0,24'h02180C,32'h0,32'h000000AB,1'b0},
    {4'd10,1'b1,2'd1,24'h021804,32'h0000FFFF,32'h0,1'b1},        // R10 enables set
    {4'd7, 1'b0,2'd1,24'h021804,32'h0,32'h00000007,1'b0},        // R7 cmd mask
    {4'd10,1'b1,2'd0,24'h021804,32'h00000003,32'h0,1'b0},        // R10 master only
    {4'd6, 1'b0,2'd0,24'h021804,32'h0,32'h00000003,1'b0},
    {4'd10,1'b1,2'd2,24'h021810,32'h12345678,32'h0,1'b1},        // R10 BAR change
    {4'd7, 1'b0,2'd2,24'h021810,32'h0,32'h12345000,1'b0},        // R7 BAR mask
    {4'd10,1'b1,2'd2,24'h021810,32'h12345678,32'h0,1'b0},        // R10 same value
    {4'd8, 1'b1,2'd2,24'h021840,32'hDEADBEEF,32'h0,1'b0},        // R8
    {4'd8, 1'b0,2'd2,24'h021840,32'h0,32'hDEADBEEF,1'b0},
    {4'd2, 1'b0,2'd0,24'h021841,32'h0,32'h000000BE,1'b0},        // R2 lane order
    {4'd3, 1'b0,2'd1,24'h021842,32'h0,32'h0000DEAD,1'b0},        // R3
    {4'd3, 1'b0,2'd3,24'h021840,32'h0,32'hDEADBEEF,1'b0},        // R3 code 3
    {4'd8, 1'b1,2'd2,24'h0218FC,32'h11223344,32'h0,1'b0},
    {4'd6, 1'b1,2'd2,24'h0218FE,32'hAABBCCDD,32'h0,1'b0},        // R6 drop past top
    {4'd6, 1'b0,2'd2,24'h0218FC,32'h0,32'hCCDD3344,1'b0},
    {4'd5, 1'b0,2'd2,24'h0218FD,32'h0,32'h0000DD33,1'b0},        // R5
    {4'd5, 1'b0,2'd2,24'h0218FE,32'h0,32'h0000CCDD,1'b0},
    {4'd5, 1'b0,2'd2,24'h0218FF,32'h0,32'h000000CC,1'b0},
    {4'd5, 1'b0,2'd1,24'h0218FF,32'h0,32'h000000CC,1'b0},
    {4'd4, 1'b0,2'd2,24'h031800,32'h0,32'hFFFFFFFF,1'b0},        // R4 other bus
    {4'd4, 1'b0,2'd1,24'h031800,32'h0,32'h0000FFFF,1'b0},
    {4'd1, 1'b0,2'd0,24'h021900,32'h0,32'h000000FF,1'b0},        // R1 other function
    {4'd4, 1'b1,2'd2,24'h022040,32'h0,32'h0,1'b0},               // R4 dropped write
    {4'd4, 1'b0,2'd2,24'h021840,32'h0,32'hDEADBEEF,1'b0},
    {4'd1, 1'b1,2'd2,24'h031810,32'hFFFFFFFF,32'h0,1'b0},        // R1 miss, no remap
    {4'd1, 1'b0,2'd2,24'h021810,32'h0,32'h12345000,1'b0},
    {4'd7, 1'b1,2'd1,24'h02183C,32'h00007777,32'h0,1'b0},        // R7 line rw, pin ro
    {4'd7, 1'b0,2'd1,24'h02183C,32'h0,32'h00000077,1'b0},
    {4'd10,1'b1,2'd0,24'h021827,32'h000000FF,32'h0,1'b1},        // R10 last BAR byte
    {4'd10,1'b1,2'd0,24'h021828,32'h000000FF,32'h0,1'b0},        // R10 past BAR range
    {4'd7, 1'b0,2'd2,24'h021828,32'h0,32'h00000000,1'b0},
    {4'd7, 1'b0,2'd2,24'h021824,32'h0,32'hFF000000,1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic access(input logic w, input logic [1:0] s, input logic [23:0] a,
                        input logic [31:0] d);
    req = 1'b1; we = w; size = s; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 rvalid at reset", 32'(rvalid), 32'd0);
    check("R9 remap at reset", 32'(remap), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [95:0] v;
      string t;
      v = TBL[i];
      t = $sformatf("R%0d vector %0d", v[95:92], i);
      access(v[91], v[90:89], v[88:65], v[64:33]);
      if (v[91]) begin
        check({t, " remap"}, 32'(remap), 32'(v[0]));
        check({t, " no rvalid"}, 32'(rvalid), 32'd0);
      end else begin
        check({t, " rvalid"}, 32'(rvalid), 32'd1);
        check({t, " rdata"}, rdata, v[32:1]);
      end
    end

    // R10 pulse lasts one cycle
    access(1'b1, 2'd0, 24'h021804, 32'h0);
    check("R10 pulse high", 32'(remap), 32'd1);
    idle();
    check("R10 pulse low next", 32'(remap), 32'd0);

    // R2 rvalid only for the cycle after the read
    access(1'b0, 2'd0, 24'h02180C, 32'h0);
    check("R2 rvalid", 32'(rvalid), 32'd1);
    idle();
    check("R2 rvalid drops", 32'(rvalid), 32'd0);

    // R9 reset in mid-run restores bytes
    rst_n = 1'b0;
    idle();
    rst_n = 1'b1;
    idle();
    access(1'b0, 2'd2, 24'h021840, 32'h0);
    check("R9 0x40 cleared", rdata, 32'h0);
    access(1'b0, 2'd0, 24'h02180C, 32'h0);
    check("R9 0x0C cleared", rdata, 32'h0);
    access(1'b0, 2'd2, 24'h021810, 32'h0);
    check("R9 BAR cleared", rdata, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule